// File: doc/BRIEF.md
# Serial Audio Link Downstream Frame Receiver

This block sits on the codec side of a 13-slot serial audio link. It runs on the link bit clock. It watches the sync line for a rising edge and samples the serial data line once per bit clock. It then cuts each frame into a 16-bit tag followed by twelve 20-bit slots. The first tag bit is taken one bit clock after the sync edge. The frame repeats at the fixed 48 kHz rate set by the controller.

The tag carries several fields. One bit marks the whole frame as valid. There is one enable flag for each slot, and a two-bit codec address. The block hands four words to the logic behind it: the control address, the control data, and the left and right DAC samples. Each word has a one-clock strobe. The control words go only to the codec whose strapped address matches the address in the tag. The strapped address also picks which slots carry this codec's left and right samples, so several codecs can share the link.

Top module: `dlr_frame_rx`

## Requirements
- R1: While reset is high and after it is released, all four strobes are 0 and all four words are 0 until a slot is delivered.
- R2: A frame starts on a rising edge of the sync line. The first tag bit is sampled at the bit-clock edge after the one that saw the edge. Bits arrive MSB first: 16 tag bits (frame bit 0 = tag bit 15), then slots 1 to 12 of 20 bits each.
- R3: Slot k ends at frame bit index 16+20k-1, counting from 0. Its word and strobe are registered on the edge that samples that bit. The strobe is high for exactly one clock.
- R4: When tag bit 15 is 0, no strobe fires in that frame.
- R5: Tag bit 15-k enables slot k. A slot whose flag is 0 is not delivered, and the output word keeps its previous value.
- R6: The control address comes from slot 1 and the control data from slot 2. Both are delivered only when tag bits 1:0 equal the strapped address.
- R7: The strapped address selects the sample slots. Address 00 and 01 use slots 3 (left) and 4 (right). Address 10 uses slots 7 and 8. Address 11 uses slots 6 and 9. This does not depend on tag bits 1:0.
- R8: Tag bits 5 to 2 have no effect on any output.
- R9: A rising sync edge during a frame aborts it. No slot of the aborted frame that had not yet ended is delivered, and bit counting restarts from the new edge.
- R10: After bit 255, data is ignored and no strobe fires until the next rising sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Frame sync line |
| sdata_i | input | 1 | Serial downstream data |
| local_id_i | input | 2 | Strapped codec address |
| cmd_addr_o | output | 20 | Control address word (slot 1) |
| cmd_addr_vld_o | output | 1 | Strobe for cmd_addr_o |
| cmd_data_o | output | 20 | Control data word (slot 2) |
| cmd_data_vld_o | output | 1 | Strobe for cmd_data_o |
| pcm_left_o | output | 20 | Left DAC sample |
| pcm_left_vld_o | output | 1 | Strobe for pcm_left_o |
| pcm_right_o | output | 20 | Right DAC sample |
| pcm_right_vld_o | output | 1 | Strobe for pcm_right_o |

## Verification
The bench puts frame bit b on the line in the clock that follows the sync edge's clock by b+1 cycles. A strobe for slot k is due at the clock edge that samples bit 16+20k-1, so it is visible right after that same edge. The bench samples the ports 5 ns after each rising edge. It records which frame bit was last driven when each sample strobe appears and compares that index with the slot end given by R3 for the mapped slot. Counts and word values are checked after each frame has drained, so held values and missing strobes are judged only once no further slot can still end.

// File: rtl/dlr_pkg.sv
`timescale 1ns/1ps
package dlr_pkg;
    localparam int TAG_W      = 16;
    localparam int SLOT_W     = 20;
    localparam int N_SLOTS    = 12;
    localparam int FRAME_BITS = TAG_W + SLOT_W * N_SLOTS;
    localparam int SLOT_IDX_W = $clog2(N_SLOTS + 1);
    localparam int POS_W      = $clog2(SLOT_W);
    localparam int ID_W       = 2;
    localparam int N_CH       = 4;

    typedef logic [SLOT_W-1:0]     word_t;
    typedef logic [SLOT_IDX_W-1:0] sidx_t;
    typedef logic [POS_W-1:0]      pos_t;
    typedef logic [ID_W-1:0]       cid_t;

    typedef enum logic [1:0] {
        CH_CADDR = 2'd0,
        CH_CDATA = 2'd1,
        CH_LEFT  = 2'd2,
        CH_RIGHT = 2'd3
    } ch_e;

    // where the receiver stands inside the current frame
    typedef struct packed {
        logic  active;
        sidx_t slot;
        pos_t  pos;
    } fpos_t;

    // a completed data slot
    typedef struct packed {
        logic  fire;
        sidx_t slot;
        word_t word;
    } sevt_t;

    // decoded tag; flags[k-1] enables slot k
    typedef struct packed {
        logic               valid;
        logic [N_SLOTS-1:0] flags;
        cid_t               id;
    } tag_t;

    function automatic pos_t last_pos(sidx_t s);
        return (s == '0) ? pos_t'(TAG_W - 1) : pos_t'(SLOT_W - 1);
    endfunction

    function automatic tag_t decode_tag(logic [TAG_W-1:0] w);
        tag_t t;
        t.valid = w[TAG_W-1];
        for (int k = 1; k <= N_SLOTS; k++) begin
            t.flags[k-1] = w[TAG_W-1-k];
        end
        t.id = w[ID_W-1:0];
        return t;
    endfunction

    // slot feeding an output channel for a given strapped address
    function automatic sidx_t ch_slot(ch_e ch, cid_t id);
        sidx_t s;
        case (ch)
            CH_CADDR: s = sidx_t'(1);
            CH_CDATA: s = sidx_t'(2);
            CH_LEFT: begin
                case (id)
                    2'b10:   s = sidx_t'(7);
                    2'b11:   s = sidx_t'(6);
                    default: s = sidx_t'(3);
                endcase
            end
            default: begin
                case (id)
                    2'b10:   s = sidx_t'(8);
                    2'b11:   s = sidx_t'(9);
                    default: s = sidx_t'(4);
                endcase
            end
        endcase
        return s;
    endfunction

    function automatic logic ch_needs_id(ch_e ch);
        return (ch == CH_CADDR) || (ch == CH_CDATA);
    endfunction
endpackage

// File: rtl/dlr_frame_track.sv
`timescale 1ns/1ps
module dlr_frame_track
    import dlr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_i,
    output fpos_t pos_o,
    output logic  start_o,
    output logic  take_o,
    output logic  last_o
);
    logic  sync_q;
    fpos_t st;

    assign start_o = sync_i && !sync_q;
    assign take_o  = st.active && !start_o;
    assign last_o  = take_o && (st.pos == last_pos(st.slot));
    assign pos_o   = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            st     <= '0;
        end else begin
            sync_q <= sync_i;
            if (start_o) begin
                st.active <= 1'b1;
                st.slot   <= '0;
                st.pos    <= '0;
            end else if (st.active) begin
                if (st.pos == last_pos(st.slot)) begin
                    st.pos <= '0;
                    if (st.slot == sidx_t'(N_SLOTS)) begin
                        st.active <= 1'b0;
                        st.slot   <= '0;
                    end else begin
                        st.slot <= st.slot + sidx_t'(1);
                    end
                end else begin
                    st.pos <= st.pos + pos_t'(1);
                end
            end
        end
    end

    // R2: a sync edge places the receiver at tag bit 15 for the next clock
    a_r2_frame_start: assert property (@(posedge clk) disable iff (rst)
        start_o |=> (st.active && st.slot == '0 && st.pos == '0));

    // R9: counting position always stays inside the frame layout
    a_r9_pos_bounds: assert property (@(posedge clk) disable iff (rst)
        st.active |-> (st.slot <= sidx_t'(N_SLOTS) && st.pos <= last_pos(st.slot)));

    // R10: after the last bit of slot 12 the receiver goes idle
    a_r10_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        (last_o && st.slot == sidx_t'(N_SLOTS)) |=> (!st.active || $past(start_o)));
endmodule

// File: rtl/dlr_slot_shift.sv
`timescale 1ns/1ps
module dlr_slot_shift
    import dlr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sdata_i,
    input  fpos_t pos_i,
    input  logic  start_i,
    input  logic  take_i,
    input  logic  last_i,
    output sevt_t evt_o,
    output tag_t  tag_o
);
    word_t shreg;
    word_t word_now;
    tag_t  tag_q;

    assign word_now   = {shreg[SLOT_W-2:0], sdata_i};
    assign evt_o.fire = last_i && (pos_i.slot != '0);
    assign evt_o.slot = pos_i.slot;
    assign evt_o.word = word_now;
    assign tag_o      = tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            tag_q <= '0;
        end else begin
            if (take_i) begin
                shreg <= word_now;
            end
            if (start_i) begin
                tag_q <= '0;
            end else if (last_i && pos_i.slot == '0) begin
                tag_q <= decode_tag(word_now[TAG_W-1:0]);
            end
        end
    end

    // R4: a new frame never inherits the previous frame's valid bit
    a_r4_tag_cleared: assert property (@(posedge clk) disable iff (rst)
        start_i |=> !tag_q.valid);

    // R3: a data slot can only complete while a frame is being received
    a_r3_evt_in_frame: assert property (@(posedge clk) disable iff (rst)
        evt_o.fire |-> (pos_i.active && !start_i));
endmodule

// File: rtl/dlr_route.sv
`timescale 1ns/1ps
module dlr_route
    import dlr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  sevt_t                  evt_i,
    input  tag_t                   tag_i,
    input  cid_t                   local_id_i,
    output word_t [N_CH-1:0]       word_o,
    output logic  [N_CH-1:0]       vld_o
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam ch_e CH = ch_e'(c);
        sidx_t want;
        logic  id_ok;
        logic  hit;

        assign want  = ch_slot(CH, local_id_i);
        assign id_ok = !ch_needs_id(CH) || (tag_i.id == local_id_i);
        assign hit   = evt_i.fire && (evt_i.slot == want) && tag_i.valid
                       && tag_i.flags[want - sidx_t'(1)] && id_ok;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_o[c]  <= 1'b0;
                word_o[c] <= '0;
            end else begin
                vld_o[c] <= hit;
                if (hit) begin
                    word_o[c] <= evt_i.word;
                end
            end
        end

        // R3: strobes are single-clock pulses
        a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
            vld_o[c] |=> !vld_o[c]);

        // R5: a word only changes together with its strobe
        a_r5_hold_word: assert property (@(posedge clk) disable iff (rst)
            !vld_o[c] |-> $stable(word_o[c]));

        // R4: no delivery from a frame whose valid bit is clear
        a_r4_needs_valid: assert property (@(posedge clk) disable iff (rst)
            vld_o[c] |-> $past(tag_i.valid));
    end

    // R3: slots end at distinct clocks, so at most one strobe per clock
    a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(vld_o));
endmodule

// File: rtl/dlr_frame_rx.sv
`timescale 1ns/1ps
module dlr_frame_rx
    import dlr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sync_i,
    input  logic        sdata_i,
    input  logic [1:0]  local_id_i,
    output logic [19:0] cmd_addr_o,
    output logic        cmd_addr_vld_o,
    output logic [19:0] cmd_data_o,
    output logic        cmd_data_vld_o,
    output logic [19:0] pcm_left_o,
    output logic        pcm_left_vld_o,
    output logic [19:0] pcm_right_o,
    output logic        pcm_right_vld_o
);
    fpos_t            fpos;
    logic             start;
    logic             take;
    logic             last;
    sevt_t            evt;
    tag_t             tag;
    word_t [N_CH-1:0] words;
    logic  [N_CH-1:0] vlds;

    dlr_frame_track u_track (
        .clk     (clk),
        .rst     (rst),
        .sync_i  (sync_i),
        .pos_o   (fpos),
        .start_o (start),
        .take_o  (take),
        .last_o  (last)
    );

    dlr_slot_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .sdata_i (sdata_i),
        .pos_i   (fpos),
        .start_i (start),
        .take_i  (take),
        .last_i  (last),
        .evt_o   (evt),
        .tag_o   (tag)
    );

    dlr_route u_route (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .tag_i      (tag),
        .local_id_i (local_id_i),
        .word_o     (words),
        .vld_o      (vlds)
    );

    assign cmd_addr_o      = words[CH_CADDR];
    assign cmd_addr_vld_o  = vlds[CH_CADDR];
    assign cmd_data_o      = words[CH_CDATA];
    assign cmd_data_vld_o  = vlds[CH_CDATA];
    assign pcm_left_o      = words[CH_LEFT];
    assign pcm_left_vld_o  = vlds[CH_LEFT];
    assign pcm_right_o     = words[CH_RIGHT];
    assign pcm_right_vld_o = vlds[CH_RIGHT];

    // R1: nothing is strobed in the clock after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (vlds == '0));
endmodule

// File: tb/dlr_frame_rx_tb.sv
`timescale 1ns/1ps
module dlr_frame_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  lid = 2'b00;
    logic [19:0] caddr, cdata, pl, pr;
    logic        caddr_v, cdata_v, pl_v, pr_v;

    int checks = 0;
    int fails  = 0;
    int drv_bit = -1;
    int n_ca, n_cd, n_l, n_r;
    int at_l, at_r;
    bit done = 1'b0;
    logic [19:0] w [1:12];

    always #10 clk = ~clk;

    dlr_frame_rx dut_i (
        .clk (clk), .rst (rst), .sync_i (sync), .sdata_i (sdata),
        .local_id_i (lid),
        .cmd_addr_o (caddr), .cmd_addr_vld_o (caddr_v),
        .cmd_data_o (cdata), .cmd_data_vld_o (cdata_v),
        .pcm_left_o (pl), .pcm_left_vld_o (pl_v),
        .pcm_right_o (pr), .pcm_right_vld_o (pr_v)
    );

    always @(posedge clk) begin
        #5;
        if (caddr_v) n_ca++;
        if (cdata_v) n_cd++;
        if (pl_v) begin n_l++; at_l = drv_bit; end
        if (pr_v) begin n_r++; at_r = drv_bit; end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int slot_end(input int k);
        return 16 + 20 * k - 1;
    endfunction

    task automatic fill_words(input int seed);
        for (int k = 1; k <= 12; k++) w[k] = 20'(seed * 20'h1111 + k * 20'h0357) ^ 20'hA5A5A;
    endtask

    function automatic logic fbit(input logic [15:0] tag, input int b);
        int s, p;
        if (b < 16) return tag[15 - b];
        if (b >= 256) return logic'(((b >> 1) ^ b) & 1);
        s = (b - 16) / 20 + 1;
        p = (b - 16) % 20;
        return w[s][19 - p];
    endfunction

    task automatic clr_mon();
        n_ca = 0; n_cd = 0; n_l = 0; n_r = 0; at_l = -1; at_r = -1;
    endtask

    task automatic run_frame(input logic [15:0] tag, input int nbits);
        @(negedge clk); sync = 1'b1; drv_bit = -1;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            if (b == 16) sync = 1'b0;
            sdata = fbit(tag, b);
            drv_bit = b;
        end
        @(negedge clk); sync = 1'b0; sdata = 1'b0; drv_bit = -1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 strobes in reset", {caddr_v, cdata_v, pl_v, pr_v}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 strobes after reset", {caddr_v, cdata_v, pl_v, pr_v}, 0);
        chk("R1 caddr word", caddr, 0);
        chk("R1 left word", pl, 0);
        chk("R1 right word", pr, 0);
    endtask

    task automatic t_full(input logic [1:0] id, input logic [15:0] tag, input int seed,
                          input int sl, input int sr, input bit cmd, input string req);
        lid = id; fill_words(seed); clr_mon();
        run_frame(tag, 256);
        chk({req, " R6 caddr count"}, n_ca, cmd ? 1 : 0);
        chk({req, " R6 cdata count"}, n_cd, cmd ? 1 : 0);
        if (cmd) begin
            chk({req, " R6 caddr word"}, caddr, w[1]);
            chk({req, " R6 cdata word"}, cdata, w[2]);
        end
        chk({req, " R7 left count"}, n_l, 1);
        chk({req, " R7 right count"}, n_r, 1);
        chk({req, " R7 left word"}, pl, w[sl]);
        chk({req, " R7 right word"}, pr, w[sr]);
        chk({req, " R3 left timing"}, at_l, slot_end(sl));
        chk({req, " R3 right timing"}, at_r, slot_end(sr));
    endtask

    task automatic t_invalid();
        logic [19:0] ca0, pl0;
        ca0 = caddr; pl0 = pl;
        lid = 2'b00; fill_words(20); clr_mon();
        run_frame(16'h7FC0, 256);
        chk("R4 no strobes", n_ca + n_cd + n_l + n_r, 0);
        chk("R5 caddr held", caddr, ca0);
        chk("R5 left held", pl, pl0);
    endtask

    task automatic t_flags();
        logic [19:0] ca0, pr0;
        ca0 = caddr; pr0 = pr;
        lid = 2'b00; fill_words(3); clr_mon();
        run_frame(16'hB7C0, 256);
        chk("R5 slot1 off count", n_ca, 0);
        chk("R5 slot4 off count", n_r, 0);
        chk("R5 caddr held", caddr, ca0);
        chk("R5 right held", pr, pr0);
        chk("R5 slot2 on", cdata, w[2]);
        chk("R5 slot3 on", pl, w[3]);
    endtask

    task automatic t_abort();
        logic [19:0] cd0;
        cd0 = cdata;
        lid = 2'b00; fill_words(8); clr_mon();
        run_frame(16'hFFC0, 45);
        chk("R9 slot1 before abort", n_ca, 1);
        chk("R9 slot1 word", caddr, w[1]);
        chk("R9 slot2 dropped", n_cd, 0);
        chk("R9 cdata held", cdata, cd0);
        chk("R9 pcm dropped", n_l + n_r, 0);
        t_full(2'b00, 16'hFFC0, 9, 3, 4, 1'b1, "R9 restart");
    endtask

    task automatic t_idle();
        lid = 2'b00; fill_words(11); clr_mon();
        run_frame(16'hFFC0, 600);
        chk("R10 caddr once", n_ca, 1);
        chk("R10 left once", n_l, 1);
        chk("R10 right once", n_r, 1);
        chk("R10 left word", pl, w[3]);
        chk("R10 left timing", at_l, slot_end(3));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full(2'b00, 16'hFFC0, 1, 3, 4, 1'b1, "R2 primary");
        t_invalid();
        t_flags();
        t_full(2'b00, 16'hFFFC, 4, 3, 4, 1'b1, "R8 reserved bits set");
        t_full(2'b10, 16'hFFC2, 5, 7, 8, 1'b1, "R7 id10");
        t_full(2'b11, 16'hFFC0, 6, 6, 9, 1'b0, "R6 id mismatch");
        t_full(2'b01, 16'hFFC1, 7, 3, 4, 1'b1, "R7 id01");
        t_abort();
        t_idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule